// File: doc/BRIEF.md
# Ethernet receive frame extractor

This block drains received frames from the receive buffer of an external Ethernet controller chip and hands them to an upper-level consumer. It starts when a receive-waiting flag is raised. It then asks for the shared chip bus and issues one throw-away pre-fetch read, because the chip's first buffer read returns stale data. After a short settling delay it reads each frame word by word through the auto-incrementing data register.

For each frame the block checks the leading marker and decodes the status byte. It reads the length, skips the 14-byte Ethernet header and keeps only the frame type, which it presents on its own output. It streams the payload over a valid/read-enable handshake and reads and discards the trailing checksum. It then peeks at the marker that follows the frame. If another frame is waiting, the block clears the pending receive interrupt in the chip and goes straight on to that frame. If the buffer is empty, it releases the bus. A malformed marker sends the block into a terminal fatal state.

Chip accesses use a simple request/acknowledge channel. `acc_stb` is held with a fixed address until the target answers with a single-cycle `acc_ack`, and read data arrives on `acc_rdata` in that same cycle. Each 16-bit word carries two buffer bytes, the earlier byte in bits 7:0.

The controller moves through these states:
- ST_IDLE goes to ST_REQ when rx_waiting is high.
- ST_REQ goes to ST_PEEK when the grant arrives.
- ST_PEEK goes to ST_SETTLE on the ack.
- ST_SETTLE goes to ST_HEAD when the delay counter expires.
- ST_HEAD goes to ST_LEN if the marker is good, otherwise to ST_FATAL.
- ST_LEN goes to ST_HDR.
- ST_HDR goes to ST_ANNOUNCE after the seventh header word.
- ST_ANNOUNCE goes to ST_FETCH, or straight to ST_CRC if the payload is empty.
- ST_FETCH goes to ST_HOLD.
- ST_HOLD goes back to ST_FETCH, or to ST_CRC after the last word has been taken.
- ST_CRC goes to ST_NEXT after the second checksum word.
- ST_NEXT goes to ST_CLR on 0x01, to ST_IDLE on 0x00, and to ST_FATAL on anything else.
- ST_CLR goes to ST_HEAD.
- ST_FATAL never leaves.

Top module: `rx_frame_extractor`

## Requirements
- R1: No chip access (`acc_stb`) is made unless `bus_req` is high and `bus_gnt` has been given. `bus_req` stays high from the grant request until the buffer is found empty or a fatal error occurs, and it is low after reset.
- R2: The first access of every bus tenure is a read of the peek register (address 0xF0) whose data is discarded. At least SETTLE_CYC idle cycles then pass before the first read of the data register (address 0xF2).
- R3: The low byte of the first data word of a frame must be 0x01, or the block enters a fatal state. In that state `fatal_error` is high, `bus_req` is low, no access is made, and `rx_waiting` is ignored until reset.
- R4: The high byte of the first word is the status. Bit 7 alone leaves `rx_erroneous` low. Any of bits 6:0 set drives `rx_erroneous` high, and the frame payload is still delivered.
- R5: The second word carries the byte length L (bits 10:0), counting the header and the 4 checksum bytes. `rx_len` reports L-18 and exactly ceil((L-18)/2) payload words are delivered, so L=18 gives an empty payload.
- R6: The seven 16-bit header words after the length word are removed from the stream. The seventh of them is presented unchanged on `rx_frame_type`.
- R7: `new_rx` is a one-cycle pulse per frame, with `rx_len`, `rx_frame_type` and `rx_erroneous` already valid. It comes before the frame's first `rx_data_valid`.
- R8: A payload word is consumed only in a cycle where `rx_data_valid` and `rx_re` are both high. While `rx_re` is low, `rx_data_valid` stays high and `rx_data` holds.
- R9: The two checksum words that follow the payload are read from the chip but never appear on `rx_data`.
- R10: After a frame the block reads the peek register (0xF0). Low byte 0x00 releases the bus and returns to idle. 0x01 writes 0x01 to the interrupt status register (0xFE) and continues with the next frame without a further pre-fetch. Any other value is fatal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_waiting | input | 1 | Receive-waiting flag from the interrupt logic |
| bus_req | output | 1 | Request for the shared chip bus |
| bus_gnt | input | 1 | Grant of the shared chip bus |
| acc_stb | output | 1 | Chip access request, held until acknowledged |
| acc_we | output | 1 | Access is a write |
| acc_addr | output | 8 | Chip register address |
| acc_wdata | output | 8 | Write data |
| acc_ack | input | 1 | One-cycle access completion |
| acc_rdata | input | 16 | Read data, valid with acc_ack |
| new_rx | output | 1 | New frame announcement pulse |
| rx_len | output | 11 | Payload length in bytes |
| rx_frame_type | output | 16 | Ethernet frame type word |
| rx_erroneous | output | 1 | Status reported a receive error |
| rx_data | output | 16 | Payload word |
| rx_data_valid | output | 1 | Payload word available |
| rx_re | input | 1 | Consumer takes the payload word |
| fatal_error | output | 1 | Terminal malformed-marker error |

## Verification
The bench's chip model returns a poisoned word for the first buffer read after each load. A design that skips the pre-fetch therefore sees a bad marker and goes fatal, and one that skips the settling delay shows too short a gap between peek and first data read. Lengths of 18 and of an odd value check the payload word count and the reported length. A design that miscounts either leaks a checksum word into the stream or drops payload. Back-to-back frames check that exactly one interrupt clear is written and that no second pre-fetch is made. A multicast-only status, an error status, a bad first marker and a bad trailing marker each check the error flag and the terminal fatal state. A stalling consumer checks that words are neither lost nor duplicated.

// File: rtl/rxx_pkg.sv
package rxx_pkg;
    localparam int WORD_W        = 16;
    localparam int HDR_WORDS     = 7;
    localparam int CRC_WORDS     = 2;
    localparam int OVERHEAD_B    = 2 * (HDR_WORDS + CRC_WORDS);
    localparam logic [7:0] MARK_FRAME = 8'h01;
    localparam logic [7:0] MARK_EMPTY = 8'h00;
    localparam logic [7:0] STATUS_ERR_MASK = 8'h7F;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_PEEK,
        ST_SETTLE,
        ST_HEAD,
        ST_LEN,
        ST_HDR,
        ST_ANNOUNCE,
        ST_FETCH,
        ST_HOLD,
        ST_CRC,
        ST_NEXT,
        ST_CLR,
        ST_FATAL
    } rxx_state_e;
endpackage

// File: rtl/rxx_down_counter.sv
module rxx_down_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] val;

    always_ff @(posedge clk) begin
        if (!rst_n)    val <= '0;
        else if (load) val <= load_val;
        else if (dec)  val <= val - 1'b1;
    end

    assign zero = (val == '0);

    // R5 / R9: word counts never wrap below zero
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> !zero);
endmodule

// File: rtl/rxx_word_decode.sv
module rxx_word_decode
    import rxx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              frame_mark,
    output logic              empty_mark,
    output logic              bad_status
);
    assign frame_mark = (word[7:0] == MARK_FRAME);
    assign empty_mark = (word[7:0] == MARK_EMPTY);
    assign bad_status = |(word[15:8] & STATUS_ERR_MASK);
endmodule

// File: rtl/rx_frame_extractor.sv
module rx_frame_extractor
    import rxx_pkg::*;
#(
    parameter int          LEN_W      = 11,
    parameter int          SETTLE_CYC = 4,
    parameter logic [7:0]  ADDR_PEEK  = 8'hF0,
    parameter logic [7:0]  ADDR_DATA  = 8'hF2,
    parameter logic [7:0]  ADDR_IRQ   = 8'hFE,
    parameter logic [7:0]  IRQ_RX_CLR = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_waiting,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              acc_stb,
    output logic              acc_we,
    output logic [7:0]        acc_addr,
    output logic [7:0]        acc_wdata,
    input  logic              acc_ack,
    input  logic [WORD_W-1:0] acc_rdata,
    output logic              new_rx,
    output logic [LEN_W-1:0]  rx_len,
    output logic [WORD_W-1:0] rx_frame_type,
    output logic              rx_erroneous,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_data_valid,
    input  logic              rx_re,
    output logic              fatal_error
);
    localparam logic [LEN_W-1:0] SETTLE_LD = LEN_W'(SETTLE_CYC);
    localparam logic [LEN_W-1:0] HDR_LD    = LEN_W'(HDR_WORDS - 1);
    localparam logic [LEN_W-1:0] CRC_LD    = LEN_W'(CRC_WORDS - 1);
    localparam logic [LEN_W-1:0] OVH_B     = LEN_W'(OVERHEAD_B);
    localparam logic [LEN_W-1:0] OVH_W     = LEN_W'(HDR_WORDS + CRC_WORDS);

    rxx_state_e st, nxt;

    logic             cnt_load, cnt_dec, cnt_zero;
    logic [LEN_W-1:0] cnt_val;
    logic             frame_mark, empty_mark, bad_status;
    logic [LEN_W-1:0] words_r, len_fld, len_pay, words_c;
    logic [LEN_W:0]   len_p1;
    logic [WORD_W-1:0] data_r, type_r;
    logic [LEN_W-1:0] len_r;
    logic             err_r;

    rxx_down_counter #(.W(LEN_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
        .dec(cnt_dec), .zero(cnt_zero)
    );

    rxx_word_decode u_dec (
        .word(acc_rdata), .frame_mark(frame_mark),
        .empty_mark(empty_mark), .bad_status(bad_status)
    );

    // length arithmetic
    assign len_fld = acc_rdata[LEN_W-1:0];
    assign len_p1  = {1'b0, len_fld} + 1'b1;
    assign len_pay = (len_fld < OVH_B) ? '0 : len_fld - OVH_B;
    assign words_c = (len_fld < OVH_B) ? '0 : len_p1[LEN_W:1] - OVH_W;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next state and counter control
    always_comb begin
        nxt      = st;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        unique case (st)
            ST_IDLE:     if (rx_waiting) nxt = ST_REQ;
            ST_REQ:      if (bus_gnt) nxt = ST_PEEK;
            ST_PEEK:     if (acc_ack) begin
                             nxt = ST_SETTLE; cnt_load = 1'b1; cnt_val = SETTLE_LD;
                         end
            ST_SETTLE:   if (cnt_zero) nxt = ST_HEAD; else cnt_dec = 1'b1;
            ST_HEAD:     if (acc_ack) nxt = frame_mark ? ST_LEN : ST_FATAL;
            ST_LEN:      if (acc_ack) begin
                             nxt = ST_HDR; cnt_load = 1'b1; cnt_val = HDR_LD;
                         end
            ST_HDR:      if (acc_ack) begin
                             if (cnt_zero) nxt = ST_ANNOUNCE; else cnt_dec = 1'b1;
                         end
            ST_ANNOUNCE: begin
                             cnt_load = 1'b1;
                             if (words_r == '0) begin nxt = ST_CRC; cnt_val = CRC_LD; end
                             else begin nxt = ST_FETCH; cnt_val = words_r; end
                         end
            ST_FETCH:    if (acc_ack) begin nxt = ST_HOLD; cnt_dec = 1'b1; end
            ST_HOLD:     if (rx_re) begin
                             if (cnt_zero) begin
                                 nxt = ST_CRC; cnt_load = 1'b1; cnt_val = CRC_LD;
                             end else nxt = ST_FETCH;
                         end
            ST_CRC:      if (acc_ack) begin
                             if (cnt_zero) nxt = ST_NEXT; else cnt_dec = 1'b1;
                         end
            ST_NEXT:     if (acc_ack) begin
                             if (frame_mark)      nxt = ST_CLR;
                             else if (empty_mark) nxt = ST_IDLE;
                             else                 nxt = ST_FATAL;
                         end
            ST_CLR:      if (acc_ack) nxt = ST_HEAD;
            ST_FATAL:    nxt = ST_FATAL;
            default:     nxt = ST_FATAL;
        endcase
    end

    // outputs
    always_comb begin
        bus_req       = !(st == ST_IDLE || st == ST_FATAL);
        acc_stb       = 1'b0;
        acc_we        = 1'b0;
        acc_addr      = ADDR_DATA;
        acc_wdata     = 8'h00;
        new_rx        = 1'b0;
        rx_data_valid = 1'b0;
        fatal_error   = 1'b0;
        unique case (st)
            ST_PEEK, ST_NEXT: begin acc_stb = 1'b1; acc_addr = ADDR_PEEK; end
            ST_HEAD, ST_LEN, ST_HDR, ST_FETCH, ST_CRC: acc_stb = 1'b1;
            ST_CLR:      begin
                             acc_stb = 1'b1; acc_we = 1'b1;
                             acc_addr = ADDR_IRQ; acc_wdata = IRQ_RX_CLR;
                         end
            ST_ANNOUNCE: new_rx = 1'b1;
            ST_HOLD:     rx_data_valid = 1'b1;
            ST_FATAL:    fatal_error = 1'b1;
            default:     ;
        endcase
    end

    // captured frame fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_r <= 1'b0; len_r <= '0; words_r <= '0;
            type_r <= '0; data_r <= '0;
        end else if (acc_ack) begin
            if (st == ST_HEAD) err_r <= bad_status;
            if (st == ST_LEN) begin len_r <= len_pay; words_r <= words_c; end
            if (st == ST_HDR && cnt_zero) type_r <= acc_rdata;
            if (st == ST_FETCH) data_r <= acc_rdata;
        end
    end

    assign rx_len        = len_r;
    assign rx_frame_type = type_r;
    assign rx_erroneous  = err_r;
    assign rx_data       = data_r;

    // pre-fetch tracking for the checker below
    logic peeked_r;
    always_ff @(posedge clk) begin
        if (!rst_n)                     peeked_r <= 1'b0;
        else if (st == ST_IDLE)         peeked_r <= 1'b0;
        else if (st == ST_PEEK && acc_ack) peeked_r <= 1'b1;
    end

    assert_access_needs_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stb |-> (bus_req && bus_gnt));
    assert_prefetch_before_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && !acc_we && acc_addr == ADDR_DATA) |-> peeked_r);
    assert_fatal_terminal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_error |=> (fatal_error && !bus_req && !acc_stb));
    assert_announce_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        new_rx |-> (!rx_data_valid ##1 !new_rx));
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_data_valid && !rx_re) |=> (rx_data_valid && $stable(rx_data)));
endmodule

// File: tb/rx_frame_extractor_tb_top.sv
`timescale 1ns/1ps
module rx_frame_extractor_tb_top;
    localparam int SETTLE = 4;
    localparam int WD     = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_waiting = 1'b0;
    logic bus_req, bus_gnt, acc_stb, acc_we, acc_ack;
    logic [7:0] acc_addr, acc_wdata;
    logic [15:0] acc_rdata;
    logic new_rx, rx_erroneous, rx_data_valid, fatal_error;
    logic rx_re = 1'b1;
    logic [10:0] rx_len;
    logic [15:0] rx_frame_type, rx_data;

    always #10 clk = ~clk;
    assign bus_gnt = bus_req;

    rx_frame_extractor #(.SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_waiting(rx_waiting),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .acc_stb(acc_stb), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_ack(acc_ack), .acc_rdata(acc_rdata),
        .new_rx(new_rx), .rx_len(rx_len), .rx_frame_type(rx_frame_type),
        .rx_erroneous(rx_erroneous), .rx_data(rx_data),
        .rx_data_valid(rx_data_valid), .rx_re(rx_re), .fatal_error(fatal_error)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    // chip buffer model
    logic [15:0] mem [0:63];
    int mlen = 0, mptr = 0, n_clr = 0, peek_cyc = -1, f2_cyc = -1;
    bit garbage = 1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) acc_ack <= 1'b0;
        else begin
            acc_ack <= acc_stb && !acc_ack;
            if (acc_stb && !acc_ack) begin
                if (acc_we) begin
                    if (acc_addr == 8'hFE && acc_wdata == 8'h01) n_clr <= n_clr + 1;
                end else begin
                    if (acc_addr == 8'hF0 && peek_cyc < 0) peek_cyc <= cyc;
                    if (acc_addr == 8'hF2 && f2_cyc < 0) f2_cyc <= cyc;
                    if (garbage) begin
                        acc_rdata <= 16'hBEEF;
                        garbage <= 0;
                    end else begin
                        acc_rdata <= (mptr < mlen) ? mem[mptr] : 16'h0000;
                        if (acc_addr == 8'hF2) mptr <= mptr + 1;
                    end
                end
            end
        end
    end

    // consumer
    bit stall = 0;
    always @(posedge clk) begin
        #2 rx_re = stall ? (cyc % 3 != 0) : 1'b1;
    end

    logic [15:0] exp_d [0:63];
    logic [15:0] got_d [0:63];
    int n_exp = 0, n_got = 0, n_frm = 0, hold_err = 0;
    logic [10:0] f_len [0:3];
    logic [15:0] f_typ [0:3];
    logic        f_err [0:3];
    logic        p_v = 0, p_re = 0;
    logic [15:0] p_d = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_data_valid && rx_re && n_got < 64) begin
                got_d[n_got] = rx_data; n_got++;
            end
            if (new_rx && n_frm < 4) begin
                f_len[n_frm] = rx_len; f_typ[n_frm] = rx_frame_type;
                f_err[n_frm] = rx_erroneous; n_frm++;
            end
            if (p_v && !p_re && !(rx_data_valid && rx_data == p_d)) hold_err++;
        end
        p_v = rx_data_valid; p_re = rx_re; p_d = rx_data;
    end

    always @(posedge clk) begin
        if (cyc >= WD && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<%0d", cyc, WD);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; rx_waiting = 0; stall = 0;
        mlen = 0; mptr = 0; n_clr = 0; peek_cyc = -1; f2_cyc = -1; garbage = 1;
        n_exp = 0; n_got = 0; n_frm = 0; hold_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic push(input logic [15:0] w);
        mem[mlen] = w; mlen++;
    endtask

    task automatic add_frame(input logic [7:0] status, input int pay_b,
                             input logic [15:0] ftype, input logic [15:0] base);
        push({status, 8'h01});
        push(16'(pay_b + 18));
        for (int i = 0; i < 6; i++) push(16'h1100 + 16'(i));
        push(ftype);
        for (int i = 0; i < (pay_b + 1) / 2; i++) begin
            push(base + 16'(i)); exp_d[n_exp] = base + 16'(i); n_exp++;
        end
        push(16'hC1C1); push(16'hC2C2);
    endtask

    task automatic run_rx();
        rx_waiting = 1;
        for (int i = 0; i < 50 && !bus_req; i++) @(negedge clk);
        rx_waiting = 0;
        for (int i = 0; i < 5000 && bus_req; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_stream(input string req);
        bit same = (n_got == n_exp);
        for (int i = 0; i < n_got && i < n_exp; i++) if (got_d[i] !== exp_d[i]) same = 0;
        chk({req, " word count"}, n_got, n_exp);
        chk({req, " payload match"}, same, 1);
        chk("R8 held word stable while stalled", hold_err, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 bus_req after reset", bus_req, 0);
        chk("R3 fatal_error after reset", fatal_error, 0);
        chk("R7 new_rx after reset", new_rx, 0);
        chk("R8 rx_data_valid after reset", rx_data_valid, 0);
        chk("R1 no access after reset", acc_stb, 0);
    endtask

    task automatic t_single();
        do_reset();
        add_frame(8'h00, 10, 16'h0008, 16'hA000); push(16'h0000);
        run_rx();
        chk("R2 prefetch before data", (peek_cyc >= 0 && peek_cyc < f2_cyc), 1);
        chk("R2 settle gap", (f2_cyc - peek_cyc) > SETTLE, 1);
        chk("R7 one frame announced", n_frm, 1);
        chk("R5 rx_len", f_len[0], 10);
        chk("R6 frame type", f_typ[0], 16'h0008);
        chk("R4 clean status", f_err[0], 0);
        chk_stream("R9 no checksum leak");
        chk("R10 empty marker no clear", n_clr, 0);
        chk("R10 bus released", bus_req, 0);
        chk("R10 not fatal", fatal_error, 0);
    endtask

    task automatic t_multicast_stall();
        do_reset();
        stall = 1;
        add_frame(8'h80, 6, 16'h0806, 16'hB000); push(16'h0000);
        run_rx();
        chk("R4 multicast bit ignored", f_err[0], 0);
        chk_stream("R8 stalled stream");
    endtask

    task automatic t_err_status();
        do_reset();
        add_frame(8'h04, 4, 16'h86DD, 16'hC000); push(16'h0000);
        run_rx();
        chk("R4 error status flagged", f_err[0], 1);
        chk_stream("R4 errored frame still delivered");
    endtask

    task automatic t_odd_len();
        do_reset();
        add_frame(8'h00, 7, 16'h0800, 16'hD000); push(16'h0000);
        run_rx();
        chk("R5 odd rx_len", f_len[0], 7);
        chk_stream("R5 odd length words");
    endtask

    task automatic t_zero_payload();
        do_reset();
        add_frame(8'h00, 0, 16'h1234, 16'hE000); push(16'h0000);
        run_rx();
        chk("R5 zero rx_len", f_len[0], 0);
        chk("R7 empty frame announced", n_frm, 1);
        chk_stream("R9 empty payload");
    endtask

    task automatic t_two_frames();
        do_reset();
        stall = 1;
        add_frame(8'h00, 4, 16'h0800, 16'h5000);
        add_frame(8'h02, 6, 16'h0806, 16'h6000);
        push(16'h0000);
        run_rx();
        chk("R10 frames announced", n_frm, 2);
        chk("R10 one interrupt clear", n_clr, 1);
        chk("R4 second frame error", f_err[1], 1);
        chk("R6 second frame type", f_typ[1], 16'h0806);
        chk("R5 second rx_len", f_len[1], 6);
        chk_stream("R10 both payloads");
        chk("R10 idle after empty", bus_req, 0);
    endtask

    task automatic t_bad_marker();
        do_reset();
        push(16'h0007); push(16'h0020);
        run_rx();
        chk("R3 bad first marker fatal", fatal_error, 1);
        chk("R3 bus released", bus_req, 0);
        chk("R3 no frame announced", n_frm, 0);
        rx_waiting = 1;
        repeat (5) @(negedge clk);
        chk("R3 rx_waiting ignored", {bus_req, acc_stb}, 0);
        rx_waiting = 0;
    endtask

    task automatic t_bad_next();
        do_reset();
        add_frame(8'h00, 2, 16'h0800, 16'h7000); push(16'h0055);
        run_rx();
        chk_stream("R10 frame before bad marker");
        chk("R10 bad next marker fatal", fatal_error, 1);
        chk("R10 no clear on bad marker", n_clr, 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_multicast_stall();
        t_err_status();
        t_odd_len();
        t_zero_payload();
        t_two_frames();
        t_bad_marker();
        t_bad_next();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule